// File: doc/BRIEF.md
# Serial Converter Readout Host

This block is the host side of a three-byte serial exchange with a 12-bit analog-to-digital converter. It drives the serial clock, chip select and data-out lines, and it samples the data-in line. A single request starts one conversion. The request carries a 3-bit channel number, a unipolar/bipolar flag and a single-ended/differential flag. The host turns these fields into a start-framed command byte that puts the converter in external-clock mode. It shifts that byte out first, then shifts out sixteen zero bits. While it does so it collects the sixteen bits the converter returns.

When the exchange ends, the host cuts the 12-bit sample out of the second and third received bytes. It presents the sample together with a one-cycle completion pulse. The serial clock is derived from the system clock. A programmable half-period count, latched when a request is accepted, sets its rate. The integrator picks that count so the serial clock stays between 100 kHz and 2 MHz.

Top module: `adc_spi_host`

## Requirements
- R1: Clock polarity 0 and phase 0. `sclk_o` idles low. `mosi_o` only changes while `sclk_o` is low. `miso_i` is sampled in the system cycle where `sclk_o` goes high.
- R2: Each conversion produces exactly 24 rising edges of `sclk_o`. `cs_no` stays low for the whole exchange.
- R3: The first 8 bits sent on `mosi_o`, MSB first, are: 1, then `chan_i[2]`, `chan_i[1]`, `chan_i[0]`, then `unipolar_i`, then `single_i`, then 1, then 1.
- R4: `mosi_o` is 0 for the 16 bits that follow the command byte.
- R5: `result_o` equals bits 6..0 of the second received byte (received order, bit 7 first) followed by bits 7..3 of the third received byte. Received bit 8 and the last three received bits are ignored.
- R6: Each half period of `sclk_o` lasts `half_div_i` system cycles. The value is latched at accept, and 0 is treated as 1. Consecutive rising edges are therefore 2*`half_div_i` cycles apart.
- R7: `cs_no` returns high `half_div_i` cycles after the last rising edge. In that same cycle `sclk_o` drops and `done_o` is high.
- R8: A request raised while `busy_o` is high is ignored. It produces no extra exchange, and the result belongs to the first request.
- R9: `busy_o` is high from the cycle after accept up to the `done_o` cycle, where it is low. `done_o` lasts one cycle. `result_o` changes only when `done_o` is high.
- R10: After reset, `cs_no`=1, `sclk_o`=0, `mosi_o`=0, `busy_o`=0, `done_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | 16 | Serial clock half period in system cycles |
| req_i | input | 1 | Start one conversion |
| chan_i | input | 3 | Channel select |
| unipolar_i | input | 1 | 1 = unipolar, 0 = bipolar |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Converted sample |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data from converter |

## Verification
A converter model returns frames in which every discarded bit is set to 1. It captures every host bit on each rising edge.
- A design that sliced the result one bit early or late would fold those ones into the sample. A design that left a stray start bit on the data-out line would corrupt the captured frame.
- The bench times the gaps between rising edges and the gap from the last edge to chip-select release, using several half-period settings. An off-by-one in the divider or an early release shows up as a wrong cycle count.
- A second request is raised in the middle of an exchange. A host that accepted it would emit an extra completion pulse or a frame with the wrong channel.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 3;
  localparam int unsigned FRAME_W = BYTE_W * N_BYTES;
  localparam int unsigned HALFS   = 2 * FRAME_W;
  localparam int unsigned HCNT_W  = $clog2(HALFS);
  localparam int unsigned RES_W   = 12;
  localparam int unsigned CH_W    = 3;

  typedef enum logic {ST_IDLE, ST_RUN} host_state_e;

  // start bit, channel, polarity, input type, external clock mode code
  function automatic logic [BYTE_W-1:0] build_cmd(logic [CH_W-1:0] ch,
                                                  logic uni, logic sgl);
    return {1'b1, ch, uni, sgl, 2'b11};
  endfunction
endpackage

// File: rtl/adc_spi_tick.sv
module adc_spi_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_spi_shift.sv
module adc_spi_shift #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         clear_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_q <= '0;
    else if (load_i)   tx_q <= load_data_i;
    else if (clear_i)  tx_q <= '0;
    else if (shift_i)  tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_q <= '0;
    else if (sample_i)  rx_q <= {rx_q[W-2:0], miso_i};
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/adc_spi_host.sv
module adc_spi_host
  import adc_spi_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   half_div_i,
  input  logic               req_i,
  input  logic [CH_W-1:0]    chan_i,
  input  logic               unipolar_i,
  input  logic               single_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [RES_W-1:0]   result_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int unsigned LAST_HALF = HALFS - 1;
  // result sits after the first received byte plus one leading bit
  localparam int unsigned RES_LSB = FRAME_W - BYTE_W - 1 - RES_W;
  localparam int unsigned RES_MSB = RES_LSB + RES_W - 1;

  host_state_e       state_q;
  logic [DIV_W-1:0]  lim_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic              sclk_q, done_q;
  logic [RES_W-1:0]  res_q;
  logic              tick, accept, rise, fall, finish;
  logic [FRAME_W-1:0] rx;

  assign accept = (state_q == ST_IDLE) && req_i;
  assign rise   = tick && !sclk_q;
  assign fall   = tick && sclk_q && (hcnt_q != HCNT_W'(LAST_HALF));
  assign finish = tick && sclk_q && (hcnt_q == HCNT_W'(LAST_HALF));

  adc_spi_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN),
    .lim_i  (lim_q),
    .tick_o (tick)
  );

  adc_spi_shift #(.W(FRAME_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i ({build_cmd(chan_i, unipolar_i, single_i), {(FRAME_W-BYTE_W){1'b0}}}),
    .shift_i     (fall),
    .sample_i    (rise),
    .clear_i     (finish),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_o        (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lim_q   <= DIV_W'(1);
      hcnt_q  <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          lim_q   <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
          hcnt_q  <= '0;
          sclk_q  <= 1'b0;
        end
        ST_RUN: if (tick) begin
          hcnt_q <= hcnt_q + 1'b1;
          if (finish) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            done_q  <= 1'b1;
            res_q   <= rx[RES_MSB:RES_LSB];
          end else begin
            sclk_q <= !sclk_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign cs_no    = (state_q != ST_RUN);
  assign sclk_o   = sclk_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_spi_host_chk.sv
module adc_spi_host_chk
  import adc_spi_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic             sclk_o,
  input logic             cs_no,
  input logic             mosi_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R1
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R1
  AST_CS_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && !done_o) |=> (busy_o || done_o)); // R8
  AST_CS_RELEASE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o); // R7
endmodule

bind adc_spi_host adc_spi_host_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .sclk_o   (sclk_o),
  .cs_no    (cs_no),
  .mosi_o   (mosi_o)
);

// File: tb/sim_adc_spi_host.sv
`timescale 1ns/1ps
module sim_adc_spi_host;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] half_div_i = 16'd50;
  logic        req_i = 1'b0;
  logic [2:0]  chan_i = '0;
  logic        unipolar_i = 1'b0;
  logic        single_i = 1'b0;
  logic        busy_o, done_o, sclk_o, cs_no, mosi_o;
  logic [11:0] result_o;
  logic        miso_i;

  always #2.5 clk_i = ~clk_i;

  adc_spi_host u0 (.*);

  typedef struct {
    logic [11:0] res;
    logic [23:0] frame;
    int          hd;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc = 0, dones = 0, pushed = 0;

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // converter model: shifts on falling edges, captures host bits on rising edges
  logic [23:0] pat = '0, cap = '0;
  int nfall = 0;
  always @(negedge sclk_o or posedge cs_no)
    if (cs_no) nfall <= 0; else nfall <= nfall + 1;
  assign miso_i = (nfall < 24) ? pat[23 - nfall] : 1'b0;
  always @(posedge sclk_o) cap <= {cap[22:0], mosi_o};

  // monitor
  logic prev_sclk = 0, prev_cs = 1;
  int rises = 0, last_rise = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      int hd;
      hd = (q.size() > 0) ? q[0].hd : 0;
      if (prev_cs && !cs_no) rises = 0;
      if (!prev_sclk && sclk_o) begin
        if (rises > 0)
          chk(cyc - last_rise == 2 * hd, "R6",
              $sformatf("rise gap act=%0d exp=%0d", cyc - last_rise, 2 * hd));
        rises++;
        last_rise = cyc;
      end
      if (!prev_cs && cs_no) begin
        chk(cyc - last_rise == hd, "R7",
            $sformatf("cs release delay act=%0d exp=%0d", cyc - last_rise, hd));
        chk(done_o == 1'b1 && sclk_o == 1'b0, "R7",
            $sformatf("done/sclk at release act=%b%b exp=10", done_o, sclk_o));
      end
      if (done_o) begin
        dones++;
        chk(busy_o == 1'b0, "R9", $sformatf("busy at done act=%b exp=0", busy_o));
        if (q.size() == 0) chk(0, "R8", "unexpected done act=1 exp=0");
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rises == 24, "R2", $sformatf("rising edges act=%0d exp=24", rises));
          chk(cap[23:16] == e.frame[23:16], "R3",
              $sformatf("cmd byte act=%h exp=%h", cap[23:16], e.frame[23:16]));
          chk(cap[15:0] == 16'h0, "R4",
              $sformatf("tail bits act=%h exp=0000", cap[15:0]));
          chk(result_o == e.res, "R5",
              $sformatf("result act=%h exp=%h", result_o, e.res));
        end
      end
    end
    prev_sclk = sclk_o;
    prev_cs   = cs_no;
  end

  task automatic run_conv(input logic [2:0] ch, input logic uni, input logic sgl,
                          input logic [11:0] res, input int hd, input bit extra);
    exp_t e;
    e.res = res; e.hd = hd;
    e.frame = {1'b1, ch, uni, sgl, 2'b11, 16'h0};
    q.push_back(e);
    pushed++;
    // discarded bits all ones so a wrong slice is visible
    pat = {8'hFF, 1'b1, res, 3'b111};
    half_div_i = 16'(hd);
    @(negedge clk_i);
    chan_i = ch; unipolar_i = uni; single_i = sgl; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1 && cs_no == 1'b0, "R9",
        $sformatf("busy/cs after accept act=%b%b exp=10", busy_o, cs_no));
    if (extra) begin
      repeat (hd * 7) @(negedge clk_i);
      chan_i = ~ch; unipolar_i = ~uni; single_i = ~sgl; half_div_i = 16'd3;
      req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    chk(cs_no == 1'b1 && busy_o == 1'b0, "R8",
        $sformatf("idle after exchange act=%b%b exp=10", cs_no, busy_o));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1 && sclk_o == 0 && mosi_o == 0 && busy_o == 0 &&
        done_o == 0 && result_o == 0, "R10",
        $sformatf("reset outs act=%b%b%b%b%b/%h exp=10000/000",
                  cs_no, sclk_o, mosi_o, busy_o, done_o, result_o));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    run_conv(3'd7, 1'b1, 1'b1, 12'hA5C, 50, 0);
    run_conv(3'd0, 1'b0, 1'b0, 12'h000, 64, 0);
    run_conv(3'd5, 1'b1, 1'b0, 12'hFFF, 80, 0);
    run_conv(3'd2, 1'b0, 1'b1, 12'h801, 50, 1);
    run_conv(3'd6, 1'b0, 1'b1, 12'h3C7, 100, 0);
    run_conv(3'd1, 1'b1, 1'b1, 12'h5A5, 57, 1);
    repeat (200) @(negedge clk_i);
    chk(dones == pushed && q.size() == 0, "R8",
        $sformatf("completions act=%0d exp=%0d", dones, pushed));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: timeout act=hung exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule